// File: doc/BRIEF.md
# Parallel Skew-Binary Increment Counter Array

This block holds a bank of counters in which every counter can step by one in the same clock cycle without a carry chain. Each counter is kept as a skew-binary word. Every digit of the word takes the value 0, 1 or 2, and the word marks the single digit that holds a 2, if there is one. Because of this, one increment rewrites at most two neighbouring digits, whatever the counter's value. A per-word enable vector selects, on each cycle, which counters step and which hold. A typical use is tallying the ones in many long unary bitstreams in parallel, so that a stochastic result becomes a count again.

One registered read port returns a selected word. The port gives the raw digits, the two-marker field, the word's sticky overflow flag and a plain binary value, which is converted combinationally from the registered word. A synchronous clear empties the whole bank. A word that is asked to step beyond its largest representable value raises its overflow flag and then holds that largest value until the bank is cleared.

Top module: `skew_counter_array`

## Requirements
- R1: A word of D digits has D digit bits and D two-marker bits. Digit i reads as 2 when marker bit i is set, and its digit bit is then 0. Otherwise digit i reads as its digit bit. Digit i has weight 2^(i+1)-1, and bit i of each field belongs to digit i.
- R2: At most one marker bit of a word is set at any time.
- R3: When an enabled word has no marker set, digit 0 steps: 0 becomes 1, and 1 becomes 2.
- R4: When an enabled word has its marker at digit k < D-1, digit k becomes 0 and digit k+1 increases by one. A digit at 1 becomes 2.
- R5: In one cycle, each word steps or holds according to its own bit of incEn (bit w belongs to word w). All words update together, whatever the position of each word's marker.
- R6: A step requested when a word's marker sits on digit D-1 sets that word's sticky overflow flag. The word then holds the value 2^(D+1)-2, and further steps have no effect on it.
- R7: A synchronous clear zeroes every digit bit, marker bit and overflow flag. It takes priority over any enables in the same cycle.
- R8: After each rising edge, the read outputs show the word at rdAddr and its overflow flag as they were stored just before that edge.
- R9: rdBinary, which is D+1 bits wide, equals the sum of digit × (2^(i+1)-1) over the read word's digits.
- R10: A synchronous active-low reset zeroes all words, all overflow flags and the read outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Synchronous clear of the whole bank |
| incEn | input | NUM_WORDS | Per-word step enable |
| rdAddr | input | max(1, clog2(NUM_WORDS)) | Word selected for reading |
| rdDigits | output | NUM_DIGITS | Digit bits of the read word |
| rdFlags | output | NUM_DIGITS | Two-marker bits of the read word |
| rdOverflow | output | 1 | Overflow flag of the read word |
| rdBinary | output | NUM_DIGITS+1 | Binary value of the read word |

## Verification
The bench builds the bank with four words of four digits each, so a word saturates at 30 after a short run of steps. This keeps the overflow and hold behaviour within a few dozen cycles, while long random enable runs still pass through every canonical digit pattern many times. With four words, a rotating read address revisits each counter every few cycles, so independent per-word stepping, clear priority and a reset in the middle of a run are all observed through the read port. Each read is compared against an integer reference count. The expected digits and markers are derived from that count by greedy skew encoding.

// File: rtl/skew_pkg.sv
package skew_pkg;
  // Strobes from the control to the datapath.
  typedef struct packed {
    logic wipe;     // zero all words and overflow flags
    logic capture;  // load the read register
    logic rdZero;   // force the read register to zero
  } ctrlStrobe_t;
endpackage

// File: rtl/skew_word_next.sv
// Next-state function of one skew-binary word. At most two digits change.
module skew_word_next #(
  parameter int NUM_DIGITS = 5
) (
  input  logic [NUM_DIGITS-1:0] curVal,
  input  logic [NUM_DIGITS-1:0] curFlg,
  output logic [NUM_DIGITS-1:0] nxtVal,
  output logic [NUM_DIGITS-1:0] nxtFlg,
  output logic                  carryOut
);
  logic                  hasTwo;
  logic [NUM_DIGITS-1:0] bump;

  always_comb begin
    hasTwo   = |curFlg;
    // The digit that gains one: the neighbour of the 2, or digit 0.
    bump     = hasTwo ? (curFlg << 1) : {{(NUM_DIGITS-1){1'b0}}, 1'b1};
    carryOut = curFlg[NUM_DIGITS-1];
    // A bumped digit at 1 becomes 2, and one at 0 becomes 1. The old 2 becomes 0.
    nxtVal   = curVal ^ bump;
    nxtFlg   = bump & curVal;
  end
endmodule

// File: rtl/skew_ctrl.sv
// Control: resolves reset, clear and enable priority.
module skew_ctrl
  import skew_pkg::*;
#(
  parameter int NUM_WORDS = 8
) (
  input  logic                 rstN,
  input  logic                 clear,
  input  logic [NUM_WORDS-1:0] incEn,
  input  logic [NUM_WORDS-1:0] satVec,
  output ctrlStrobe_t          strobe,
  output logic [NUM_WORDS-1:0] stepVec
);
  always_comb begin
    strobe.wipe    = !rstN || clear;
    strobe.capture = rstN;
    strobe.rdZero  = !rstN;
    stepVec        = strobe.wipe ? '0 : (incEn & ~satVec);
  end
endmodule

// File: rtl/skew_datapath.sv
// Storage of all words, parallel stepping and the registered read port.
module skew_datapath
  import skew_pkg::*;
#(
  parameter int NUM_WORDS  = 8,
  parameter int NUM_DIGITS = 5,
  localparam int ADDR_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                  clk,
  input  ctrlStrobe_t           strobe,
  input  logic [NUM_WORDS-1:0]  stepVec,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [NUM_WORDS-1:0]  satVec,
  output logic [NUM_DIGITS-1:0] rdVal,
  output logic [NUM_DIGITS-1:0] rdFlg,
  output logic                  rdOvf
);
  logic [NUM_DIGITS-1:0] valMem [NUM_WORDS];
  logic [NUM_DIGITS-1:0] flgMem [NUM_WORDS];
  logic [NUM_DIGITS-1:0] valNxt [NUM_WORDS];
  logic [NUM_DIGITS-1:0] flgNxt [NUM_WORDS];
  logic [NUM_WORDS-1:0]  carryVec;
  logic [NUM_WORDS-1:0]  ovfMem;

  assign satVec = ovfMem;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    skew_word_next #(.NUM_DIGITS(NUM_DIGITS)) i_next (
      .curVal  (valMem[w]),
      .curFlg  (flgMem[w]),
      .nxtVal  (valNxt[w]),
      .nxtFlg  (flgNxt[w]),
      .carryOut(carryVec[w])
    );

    always_ff @(posedge clk) begin
      if (strobe.wipe) begin
        valMem[w] <= '0;
        flgMem[w] <= '0;
        ovfMem[w] <= 1'b0;
      end else if (stepVec[w]) begin
        if (carryVec[w]) begin
          ovfMem[w] <= 1'b1;  // saturate: keep the largest value
        end else begin
          valMem[w] <= valNxt[w];
          flgMem[w] <= flgNxt[w];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.rdZero) begin
      rdVal <= '0;
      rdFlg <= '0;
      rdOvf <= 1'b0;
    end else if (strobe.capture) begin
      if (32'(rdAddr) < NUM_WORDS) begin
        rdVal <= valMem[rdAddr];
        rdFlg <= flgMem[rdAddr];
        rdOvf <= ovfMem[rdAddr];
      end else begin
        rdVal <= '0;
        rdFlg <= '0;
        rdOvf <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/skew_to_bin.sv
// Combinational skew-binary to binary conversion.
module skew_to_bin #(
  parameter int NUM_DIGITS = 5,
  localparam int OUT_W     = NUM_DIGITS + 1
) (
  input  logic [NUM_DIGITS-1:0] digVal,
  input  logic [NUM_DIGITS-1:0] digFlg,
  output logic [OUT_W-1:0]      binOut
);
  always_comb begin
    binOut = '0;
    for (int i = 0; i < NUM_DIGITS; i++) begin
      if (digFlg[i])
        binOut = binOut + ((OUT_W'(1) << (i + 2)) - OUT_W'(2));
      else if (digVal[i])
        binOut = binOut + ((OUT_W'(1) << (i + 1)) - OUT_W'(1));
    end
  end
endmodule

// File: rtl/skew_counter_array.sv
module skew_counter_array
  import skew_pkg::*;
#(
  parameter int NUM_WORDS  = 8,
  parameter int NUM_DIGITS = 5,
  localparam int ADDR_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int OUT_W     = NUM_DIGITS + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  clear,
  input  logic [NUM_WORDS-1:0]  incEn,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [NUM_DIGITS-1:0] rdDigits,
  output logic [NUM_DIGITS-1:0] rdFlags,
  output logic                  rdOverflow,
  output logic [OUT_W-1:0]      rdBinary
);
  ctrlStrobe_t          strobe;
  logic [NUM_WORDS-1:0] stepVec;
  logic [NUM_WORDS-1:0] satVec;

  skew_ctrl #(.NUM_WORDS(NUM_WORDS)) i_ctrl (
    .rstN   (rstN),
    .clear  (clear),
    .incEn  (incEn),
    .satVec (satVec),
    .strobe (strobe),
    .stepVec(stepVec)
  );

  skew_datapath #(.NUM_WORDS(NUM_WORDS), .NUM_DIGITS(NUM_DIGITS)) i_dp (
    .clk    (clk),
    .strobe (strobe),
    .stepVec(stepVec),
    .rdAddr (rdAddr),
    .satVec (satVec),
    .rdVal  (rdDigits),
    .rdFlg  (rdFlags),
    .rdOvf  (rdOverflow)
  );

  skew_to_bin #(.NUM_DIGITS(NUM_DIGITS)) i_conv (
    .digVal(rdDigits),
    .digFlg(rdFlags),
    .binOut(rdBinary)
  );
endmodule

// File: rtl/skew_counter_array_chk.sv
module skew_counter_array_chk #(
  parameter int NUM_WORDS  = 8,
  parameter int NUM_DIGITS = 5,
  localparam int OUT_W     = NUM_DIGITS + 1
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  clear,
  input logic [NUM_DIGITS-1:0] rdDigits,
  input logic [NUM_DIGITS-1:0] rdFlags,
  input logic                  rdOverflow,
  input logic [OUT_W-1:0]      rdBinary,
  input logic [NUM_WORDS-1:0]  satVec,
  input logic [NUM_WORDS-1:0]  stepVec
);
  localparam logic [OUT_W-1:0] MAX_VAL = (OUT_W'(1) << OUT_W) - OUT_W'(2);

  p_one_marker_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rdFlags));

  p_marker_clears_digit_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rdFlags & rdDigits) == '0);

  p_binary_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    rdBinary <= MAX_VAL);

  p_overflow_at_max_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdOverflow |-> rdBinary == MAX_VAL);

  p_no_step_saturated_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stepVec & satVec) == '0);

  p_sat_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    !clear |=> ((satVec & $past(satVec)) == $past(satVec)));

  p_clear_blocks_steps_r7: assert property (@(posedge clk) disable iff (!rstN)
    clear |-> stepVec == '0);

  p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> ##1 (rdBinary == '0 && !rdOverflow));
endmodule

bind skew_counter_array skew_counter_array_chk #(
  .NUM_WORDS (NUM_WORDS),
  .NUM_DIGITS(NUM_DIGITS)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .clear     (clear),
  .rdDigits  (rdDigits),
  .rdFlags   (rdFlags),
  .rdOverflow(rdOverflow),
  .rdBinary  (rdBinary),
  .satVec    (satVec),
  .stepVec   (stepVec)
);

// File: tb/test_skew_counter_array.sv
`timescale 1ns/1ps
module test_skew_counter_array;
  localparam int NW   = 4;
  localparam int ND   = 4;
  localparam int AW   = 2;
  localparam int OW   = ND + 1;
  localparam int MAXV = (1 << OW) - 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          clear = 1'b0;
  logic [NW-1:0] incEn = '0;
  logic [AW-1:0] rdAddr = '0;
  logic [ND-1:0] rdDigits, rdFlags;
  logic          rdOverflow;
  logic [OW-1:0] rdBinary;

  int total = 0;
  int bad = 0;
  int cnt [NW];
  bit ovfM [NW];

  always #2 clk = ~clk;

  skew_counter_array #(.NUM_WORDS(NW), .NUM_DIGITS(ND)) i_skew_counter_array (
    .clk(clk), .rstN(rstN), .clear(clear), .incEn(incEn), .rdAddr(rdAddr),
    .rdDigits(rdDigits), .rdFlags(rdFlags), .rdOverflow(rdOverflow), .rdBinary(rdBinary)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Greedy skew encoding of an integer (R1 digit layout).
  task automatic encode(int v, output logic [ND-1:0] dv, output logic [ND-1:0] df);
    dv = '0;
    df = '0;
    for (int i = ND - 1; i >= 0; i--) begin
      int w = (1 << (i + 1)) - 1;
      if (v >= 2 * w) begin df[i] = 1'b1; v -= 2 * w; end
      else if (v >= w) begin dv[i] = 1'b1; v -= w; end
    end
  endtask

  task automatic compare(int expV, bit expO, string tag);
    logic [ND-1:0] ev, ef;
    encode(expV, ev, ef);
    check(rdBinary == OW'(expV), {tag, " R9 R8 binary"}, int'(rdBinary), expV);
    check(rdOverflow == expO, {tag, " R6 overflow"}, int'(rdOverflow), int'(expO));
    check(rdDigits == ev, {tag, " R1 R3 R4 digits"}, int'(rdDigits), int'(ev));
    check(rdFlags == ef, {tag, " R1 R3 R4 markers"}, int'(rdFlags), int'(ef));
    check($countones(rdFlags) <= 1, {tag, " R2 one marker"}, $countones(rdFlags), 1);
  endtask

  // One cycle: drive at the falling edge, model the rising edge, sample 1 ns after it.
  task automatic cyc(logic [NW-1:0] en, bit clr, int addr, bit rst, string tag);
    int expV;
    bit expO;
    incEn  = en;
    clear  = clr;
    rdAddr = AW'(addr);
    rstN   = !rst;
    // R8: the read register captures the word as it stood before the edge.
    expV = rst ? 0 : cnt[addr];
    expO = rst ? 1'b0 : ovfM[addr];
    for (int w = 0; w < NW; w++) begin
      if (rst || clr) begin
        cnt[w] = 0;
        ovfM[w] = 1'b0;
      end else if (en[w] && !ovfM[w]) begin
        if (cnt[w] == MAXV) ovfM[w] = 1'b1;
        else cnt[w]++;
      end
    end
    @(posedge clk);
    #1;
    compare(expV, expO, tag);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < NW; w++) begin cnt[w] = 0; ovfM[w] = 1'b0; end
    @(negedge clk);
    for (int i = 0; i < 3; i++) cyc('1, 1'b0, i % NW, 1'b1, "R10 reset");
    // R10: reset state observed through every word.
    for (int a = 0; a < NW; a++) cyc('0, 1'b0, a, 1'b0, "R10 after reset");
    // R3 R4 R5: all words stepping together.
    for (int i = 0; i < 12; i++) cyc('1, 1'b0, i % NW, 1'b0, "R5 all steps");
    // R5: alternating subsets with markers at differing positions.
    for (int i = 0; i < 16; i++) cyc((i % 2) ? 4'b0101 : 4'b1011, 1'b0, i % NW, 1'b0, "R5 subsets");
    // R6: drive word 0 beyond saturation.
    for (int i = 0; i < 40; i++) cyc(4'b0001, 1'b0, 0, 1'b0, "R6 saturate");
    for (int a = 0; a < NW; a++) cyc(4'b0001, 1'b0, a, 1'b0, "R6 hold");
    // R7: clear with every enable set wins.
    cyc('1, 1'b1, 0, 1'b0, "R7 clear");
    for (int a = 0; a < NW; a++) cyc('0, 1'b0, a, 1'b0, "R7 after clear");
    // Random enables with rare clears (R5 R7).
    for (int i = 0; i < 1500; i++) begin
      logic [NW-1:0] en = NW'($urandom);
      bit clr = ($urandom % 97) == 0;
      cyc(en, clr, i % NW, 1'b0, "R5 random");
    end
    // Random run with dense enables so that words saturate (R6).
    for (int i = 0; i < 200; i++) cyc(NW'($urandom) | 4'b1100, 1'b0, $urandom % NW, 1'b0, "R6 random");
    // R10: reset in the middle of a run.
    cyc('1, 1'b0, 3, 1'b1, "R10 mid reset");
    for (int a = 0; a < NW; a++) cyc('0, 1'b0, a, 1'b0, "R10 after mid reset");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule